// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Data Cache

This block is a data cache that sits between a processor load/store unit and a line-granular memory port. It holds 64 KB in 64-byte lines, organised as two ways per set. On a hit the requested 8-byte word is read or written within the same cycle. On a miss a least-recently-used policy picks a victim. A dirty victim is parked in a one-entry victim buffer, from which it drains to memory. The missing line is then fetched whole, and the stalled request completes once the line is installed. Writes allocate on a miss and leave the line dirty. Memory is never touched on a hit.

The processor side uses valid/ready. The requester raises `req_valid` with address, direction and write data, and holds all of them stable until it sees `req_ready` high. The cache raises `req_ready` only in the cycle that completes the access. `rsp_rdata` and `rsp_hit` are meaningful only in that cycle. Both memory channels are valid/ready as well. The cache holds `rf_req_valid` and `wb_valid` together with their address and data until the memory accepts them. The memory may hold off write-backs for as long as it likes. While `rf_rsp_ready` is high the cache accepts a refill line in any cycle.

Top module: `wbc_cache`

## Requirements
- R1: Address bits [5:0] are the byte offset within a line. Bits [14:6] select one of 512 sets. Bits [39:15] form the 25-bit tag. An address that differs from a cached one in any tag or set bit misses.
- R2: After reset every line is invalid and clean. The first access to any address misses, and neither `wb_valid` nor `rf_req_valid` is high while idle.
- R3: A request whose tag matches a valid way of its set completes in the same cycle. `req_ready` and `rsp_hit` are both high, and `rsp_rdata` holds word k = address bits [5:3], which is bits [64k+63:64k] of the 512-bit line.
- R4: A write hit replaces only the selected 8-byte word in the cache and marks the line dirty. The other words of the line keep their values, and no refill request or write-back is issued.
- R5: Each set keeps one replacement bit that names the way not used by the latest hit or fill. When both ways are valid, that way is the victim.
- R6: On a miss an invalid way is filled before any valid way is evicted. When both ways are invalid, way 0 is filled.
- R7: A dirty victim is sent out on the write-back channel as a whole line, with its line-aligned address, exactly once. A clean victim produces no write-back.
- R8: A miss holds `req_ready` low and issues a line-aligned refill request, then installs the returned line. The request then completes with `req_ready` high and `rsp_hit` low, and returns the requested word.
- R9: A write miss allocates the line, merges the 8-byte write data into the fetched line, and leaves it dirty.
- R10: The victim buffer holds one line. A new write-back waits until it has drained. A refill for a different line may go out while it is full, but a refill for the line it holds waits until that line has drained.
- R11: `req_ready` is high only while `req_valid` is high. A refill request or write-back that is not yet accepted stays valid, with unchanged address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Request completes this cycle |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | 40 | Byte address of the access |
| req_wdata | input | 64 | Store data |
| rsp_rdata | output | 64 | Load data, valid with req_ready |
| rsp_hit | output | 1 | Request hit without a miss sequence |
| rf_req_valid | output | 1 | Refill read request |
| rf_req_ready | input | 1 | Memory accepts refill request |
| rf_req_addr | output | 40 | Line-aligned refill address |
| rf_rsp_valid | input | 1 | Refill line present |
| rf_rsp_ready | output | 1 | Cache waiting for refill line |
| rf_rsp_line | input | 512 | Refill line data |
| wb_valid | output | 1 | Victim buffer holds a line to write |
| wb_ready | input | 1 | Memory accepts write-back |
| wb_addr | output | 40 | Line-aligned write-back address |
| wb_line | output | 512 | Write-back line data |

## Verification
A corrupted tag, valid or dirty bit shows at the ports the next time its set is touched. The hit/miss verdict in the first cycle of the request changes, or a write-back appears that should not, or an expected one is missing. A wrong replacement bit evicts the wrong line, which surfaces as an unexpected write-back address or as a miss on a line that should still be present. Wrong word selection or a lost merge shows up as wrong load data in the completing cycle, sometimes only after the line has made a round trip through memory. The stale-refill hazard is provoked by stalling write-backs and then touching the parked line at once, so fetching too early returns old data.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_EVICT,
    ST_REQ,
    ST_WAIT
  } wbc_state_e;
endpackage

// File: rtl/wbc_way.sv
// One way of the cache: tag, valid, dirty and line storage.
module wbc_way #(
  parameter int SETS   = 512,
  parameter int IDX_W  = 9,
  parameter int TAG_W  = 25,
  parameter int LINE_W = 512,
  parameter int WORD_W = 64,
  parameter int WSEL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic              rd_dirty,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [LINE_W-1:0] rd_line,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [LINE_W-1:0] fill_line,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WSEL_W-1:0] wr_sel,
  input  logic [WORD_W-1:0] wr_word
);
  logic [SETS-1:0]   valid_q;
  logic [SETS-1:0]   dirty_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [LINE_W-1:0] data_q [SETS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      if (fill_en) begin
        valid_q[fill_idx] <= 1'b1;
        dirty_q[fill_idx] <= 1'b0;
      end
      if (wr_en) dirty_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[fill_idx]  <= fill_tag;
      data_q[fill_idx] <= fill_line;
    end else if (wr_en) begin
      data_q[wr_idx][wr_sel*WORD_W +: WORD_W] <= wr_word;
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_line  = data_q[rd_idx];
endmodule

// File: rtl/wbc_lru.sv
// One replacement bit per set, naming the way to evict next.
module wbc_lru #(
  parameter int SETS  = 512,
  parameter int IDX_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_victim,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_used
);
  logic [SETS-1:0] victim_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      victim_q <= '0;
    else if (upd_en) victim_q[upd_idx] <= ~upd_used;
  end

  assign rd_victim = victim_q[rd_idx];
endmodule

// File: rtl/wbc_vbuf.sv
// Single-entry victim buffer with valid/ready on both sides.
module wbc_vbuf #(
  parameter int ADDR_W = 40,
  parameter int LINE_W = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [LINE_W-1:0] in_line,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [LINE_W-1:0] out_line
);
  logic              full_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LINE_W-1:0] line_q;

  assign in_ready  = ~full_q;
  assign out_valid = full_q;
  assign out_addr  = addr_q;
  assign out_line  = line_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                     full_q <= 1'b0;
    else if (in_valid && in_ready)  full_q <= 1'b1;
    else if (out_valid && out_ready) full_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) begin
      addr_q <= in_addr;
      line_q <= in_line;
    end
  end
endmodule

// File: rtl/wbc_cache.sv
module wbc_cache #(
  parameter int ADDR_W      = 40,
  parameter int CACHE_BYTES = 65536,
  parameter int LINE_BYTES  = 64,
  parameter int WORD_W      = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_we,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [WORD_W-1:0]       req_wdata,
  output logic [WORD_W-1:0]       rsp_rdata,
  output logic                    rsp_hit,
  output logic                    rf_req_valid,
  input  logic                    rf_req_ready,
  output logic [ADDR_W-1:0]       rf_req_addr,
  input  logic                    rf_rsp_valid,
  output logic                    rf_rsp_ready,
  input  logic [LINE_BYTES*8-1:0] rf_rsp_line,
  output logic                    wb_valid,
  input  logic                    wb_ready,
  output logic [ADDR_W-1:0]       wb_addr,
  output logic [LINE_BYTES*8-1:0] wb_line
);
  import wbc_pkg::*;

  localparam int WAYS   = 2;
  localparam int LINE_W = LINE_BYTES * 8;
  localparam int SETS   = CACHE_BYTES / (LINE_BYTES * WAYS);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int WSEL_W = $clog2(LINE_W / WORD_W);
  localparam int BSEL_W = OFF_W - WSEL_W;

  // Request address fields
  logic [TAG_W-1:0]  a_tag;
  logic [IDX_W-1:0]  a_idx;
  logic [WSEL_W-1:0] a_wsel;
  logic [BSEL_W-1:0] unused_bsel;
  assign a_tag       = req_addr[ADDR_W-1 -: TAG_W];
  assign a_idx       = req_addr[OFF_W +: IDX_W];
  assign a_wsel      = req_addr[OFF_W-1 -: WSEL_W];
  assign unused_bsel = req_addr[BSEL_W-1:0];

  // Miss context
  wbc_state_e       st_q;
  logic             m_way, missed_q;
  logic [IDX_W-1:0] m_idx;
  logic [TAG_W-1:0] m_tag;

  logic [WAYS-1:0]   w_valid, w_dirty, w_hit, w_fill, w_wr;
  logic [TAG_W-1:0]  w_tag  [WAYS];
  logic [LINE_W-1:0] w_line [WAYS];
  logic [IDX_W-1:0]  rd_idx;
  logic              fill_go, wr_go, hit_any, hit_way;
  logic              lru_victim, pick_way, pick_dirty;
  logic              vb_in_ready, hazard;

  assign rd_idx  = (st_q == ST_IDLE) ? a_idx : m_idx;
  assign fill_go = (st_q == ST_WAIT) && rf_rsp_valid;

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    wbc_way #(
      .SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W),
      .LINE_W(LINE_W), .WORD_W(WORD_W), .WSEL_W(WSEL_W)
    ) u_way (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (rd_idx),
      .rd_valid (w_valid[g]),
      .rd_dirty (w_dirty[g]),
      .rd_tag   (w_tag[g]),
      .rd_line  (w_line[g]),
      .fill_en  (w_fill[g]),
      .fill_idx (m_idx),
      .fill_tag (m_tag),
      .fill_line(rf_rsp_line),
      .wr_en    (w_wr[g]),
      .wr_idx   (a_idx),
      .wr_sel   (a_wsel),
      .wr_word  (req_wdata)
    );
    assign w_hit[g]  = w_valid[g] && (w_tag[g] == a_tag);
    assign w_fill[g] = fill_go && (m_way == 1'(g));
    assign w_wr[g]   = wr_go && w_hit[g];
  end

  // Hit path
  logic [LINE_W-1:0] hit_line;
  assign hit_any   = |w_hit;
  assign hit_way   = w_hit[1];
  assign hit_line  = w_line[hit_way];
  assign rsp_rdata = hit_line[a_wsel*WORD_W +: WORD_W];
  assign req_ready = (st_q == ST_IDLE) && req_valid && hit_any;
  assign rsp_hit   = req_ready && !missed_q;
  assign wr_go     = req_ready && req_we;

  // Replacement
  wbc_lru #(.SETS(SETS), .IDX_W(IDX_W)) u_lru (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (a_idx),
    .rd_victim(lru_victim),
    .upd_en   (req_ready || fill_go),
    .upd_idx  (fill_go ? m_idx : a_idx),
    .upd_used (fill_go ? m_way : hit_way)
  );

  assign pick_way   = !w_valid[0] ? 1'b0 : (!w_valid[1] ? 1'b1 : lru_victim);
  assign pick_dirty = w_valid[pick_way] && w_dirty[pick_way];

  // Victim buffer
  wbc_vbuf #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_vbuf (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (st_q == ST_EVICT),
    .in_ready (vb_in_ready),
    .in_addr  ({w_tag[m_way], m_idx, {OFF_W{1'b0}}}),
    .in_line  (w_line[m_way]),
    .out_valid(wb_valid),
    .out_ready(wb_ready),
    .out_addr (wb_addr),
    .out_line (wb_line)
  );

  // Refill
  assign hazard       = wb_valid && (wb_addr[ADDR_W-1:OFF_W] == {m_tag, m_idx});
  assign rf_req_valid = (st_q == ST_REQ) && !hazard;
  assign rf_req_addr  = {m_tag, m_idx, {OFF_W{1'b0}}};
  assign rf_rsp_ready = (st_q == ST_WAIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      missed_q <= 1'b0;
      m_way    <= 1'b0;
      m_idx    <= '0;
      m_tag    <= '0;
    end else begin
      if (req_ready) missed_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_valid && !hit_any) begin
          m_way    <= pick_way;
          m_idx    <= a_idx;
          m_tag    <= a_tag;
          missed_q <= 1'b1;
          st_q     <= pick_dirty ? ST_EVICT : ST_REQ;
        end
        ST_EVICT: if (vb_in_ready)               st_q <= ST_REQ;
        ST_REQ:   if (rf_req_valid && rf_req_ready) st_q <= ST_WAIT;
        ST_WAIT:  if (rf_rsp_valid)              st_q <= ST_IDLE;
        default:                                 st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wbc_cache_chk.sv
module wbc_cache_chk #(
  parameter int ADDR_W = 40,
  parameter int LINE_W = 512,
  parameter int OFF_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_hit,
  input logic              rf_req_valid,
  input logic              rf_req_ready,
  input logic [ADDR_W-1:0] rf_req_addr,
  input logic              rf_rsp_ready,
  input logic              wb_valid,
  input logic              wb_ready,
  input logic [ADDR_W-1:0] wb_addr,
  input logic [LINE_W-1:0] wb_line
);
  p_ready_needs_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> req_valid);

  p_hit_is_complete_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> req_ready);

  p_hit_no_memory_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!rf_req_valid && !rf_rsp_ready));

  p_refill_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_req_valid && !rf_req_ready) |=> (rf_req_valid && $stable(rf_req_addr)));

  p_wb_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr) && $stable(wb_line)));

  p_refill_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rf_req_valid |-> (rf_req_addr[OFF_W-1:0] == '0));

  p_no_stale_refill_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_req_valid && wb_valid) |-> (rf_req_addr[ADDR_W-1:OFF_W] != wb_addr[ADDR_W-1:OFF_W]));
endmodule

bind wbc_cache wbc_cache_chk #(
  .ADDR_W(ADDR_W), .LINE_W(LINE_W), .OFF_W(OFF_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .rsp_hit     (rsp_hit),
  .rf_req_valid(rf_req_valid),
  .rf_req_ready(rf_req_ready),
  .rf_req_addr (rf_req_addr),
  .rf_rsp_ready(rf_rsp_ready),
  .wb_valid    (wb_valid),
  .wb_ready    (wb_ready),
  .wb_addr     (wb_addr),
  .wb_line     (wb_line)
);

// File: tb/wbc_cache_bench.sv
module wbc_cache_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic         req_valid = 1'b0, req_we = 1'b0;
  logic [39:0]  req_addr = '0;
  logic [63:0]  req_wdata = '0;
  logic         req_ready, rsp_hit;
  logic [63:0]  rsp_rdata;
  logic         rf_req_valid, rf_rsp_ready, wb_valid;
  logic         rf_req_ready = 1'b0, rf_rsp_valid = 1'b0, wb_ready = 1'b0;
  logic [39:0]  rf_req_addr, wb_addr;
  logic [511:0] rf_rsp_line = '0;
  logic [511:0] wb_line;

  wbc_cache u_wbc_cache (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .rsp_hit(rsp_hit),
    .rf_req_valid(rf_req_valid), .rf_req_ready(rf_req_ready), .rf_req_addr(rf_req_addr),
    .rf_rsp_valid(rf_rsp_valid), .rf_rsp_ready(rf_rsp_ready), .rf_rsp_line(rf_rsp_line),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr), .wb_line(wb_line)
  );

  int n_run = 0, n_fail = 0;

  task automatic chk(bit ok, string rq, string what, logic [511:0] act, logic [511:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // Golden word store, bench memory and cache-state model
  logic [63:0]  gmem [logic [36:0]];
  logic [511:0] bmem [logic [33:0]];
  logic [24:0]  mtag [1024];
  bit           mval [1024];
  bit           mdirty [1024];
  bit           mlru [512];
  logic [39:0]  exp_wb_addr [$];
  logic [511:0] exp_wb_line [$];
  int           rf_count = 0;
  int           wb_block = 0;

  function automatic logic [63:0] gdef(logic [36:0] wa);
    return {27'h5A5A5A5, wa};
  endfunction

  function automatic logic [63:0] gword(logic [36:0] wa);
    if (gmem.exists(wa)) return gmem[wa];
    return gdef(wa);
  endfunction

  function automatic logic [511:0] golden_line(logic [33:0] la);
    logic [511:0] l;
    for (int k = 0; k < 8; k++) l[k*64 +: 64] = gword({la, 3'(k)});
    return l;
  endfunction

  function automatic logic [511:0] mem_line(logic [33:0] la);
    logic [511:0] l;
    if (bmem.exists(la)) return bmem[la];
    for (int k = 0; k < 8; k++) l[k*64 +: 64] = gdef({la, 3'(k)});
    return l;
  endfunction

  function automatic logic [39:0] mk(logic [24:0] t, logic [8:0] s, logic [2:0] w);
    return {t, s, w, 3'b000};
  endfunction

  // Memory side: refill with latency, write-back sink with stall control
  int          cyc = 0, pcnt = 0;
  bit          pend = 0;
  logic [39:0] paddr, ea;
  logic [511:0] el;

  always @(posedge clk) begin
    if (!rst_n) begin
      rf_req_ready <= 1'b0;
      rf_rsp_valid <= 1'b0;
      wb_ready     <= 1'b0;
    end else begin
      cyc++;
      rf_req_ready <= (cyc % 2) == 1;
      wb_ready     <= (wb_block == 0);
      if (wb_block > 0) wb_block--;
      if (rf_rsp_valid && rf_rsp_ready) rf_rsp_valid <= 1'b0;
      else if (pend) begin
        if (pcnt == 0) begin
          rf_rsp_valid <= 1'b1;
          rf_rsp_line  <= mem_line(paddr[39:6]);
          pend = 0;
        end else pcnt--;
      end
      if (rf_req_valid && rf_req_ready) begin
        pend = 1; pcnt = 2; paddr = rf_req_addr; rf_count++;
      end
      if (wb_valid && wb_ready) begin
        if (exp_wb_addr.size() == 0) chk(1'b0, "R7", "unexpected write-back", wb_addr, '0);
        else begin
          ea = exp_wb_addr.pop_front();
          el = exp_wb_line.pop_front();
          chk(wb_addr == ea, "R7", "write-back address", wb_addr, ea);
          chk(wb_line == el, "R7", "write-back line", wb_line, el);
        end
        bmem[wb_addr[39:6]] = wb_line;
      end
    end
  end

  // One processor access, compared against the model on every clock
  task automatic access(bit we, logic [39:0] addr, logic [63:0] wd, string rq);
    int s = int'(addr[14:6]);
    logic [24:0] t = addr[39:15];
    logic [36:0] wa = addr[39:3];
    bit exp_hit = 0;
    int hw = 0, vw = 0, guard = 0, rf0;
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = addr; req_wdata = wd;
    rf0 = rf_count;
    #1;
    for (int w = 0; w < 2; w++)
      if (mval[s*2+w] && mtag[s*2+w] == t) begin exp_hit = 1; hw = w; end
    chk(req_ready == exp_hit, exp_hit ? "R3" : "R8", "ready in first cycle", req_ready, exp_hit);
    if (!exp_hit) begin
      vw = !mval[s*2] ? 0 : (!mval[s*2+1] ? 1 : int'(mlru[s]));
      if (mval[s*2+vw] && mdirty[s*2+vw]) begin
        exp_wb_addr.push_back({mtag[s*2+vw], 9'(s), 6'b0});
        exp_wb_line.push_back(golden_line({mtag[s*2+vw], 9'(s)}));
      end
      mtag[s*2+vw] = t; mval[s*2+vw] = 1; mdirty[s*2+vw] = 0;
      mlru[s] = !vw[0];
      hw = vw;
    end
    while (!req_ready && guard < 500) begin
      chk(rsp_hit == 1'b0, "R8", "hit flag during miss", rsp_hit, 0);
      @(negedge clk); #1;
      guard++;
    end
    if (!req_ready) chk(1'b0, rq, "request never completed", 0, 1);
    else begin
      chk(rsp_hit == exp_hit, rq, "hit flag at completion", rsp_hit, exp_hit);
      if (!we) chk(rsp_rdata == gword(wa), rq, "load data", rsp_rdata, gword(wa));
      if (exp_hit) chk(rf_count == rf0, "R4", "no refill on hit", rf_count, rf0);
    end
    mlru[s] = !hw[0];
    if (we) begin mdirty[s*2+hw] = 1; gmem[wa] = wd; end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    // R2: idle after reset
    chk(wb_valid == 0, "R2", "wb_valid after reset", wb_valid, 0);
    chk(rf_req_valid == 0, "R2", "rf_req_valid after reset", rf_req_valid, 0);
    chk(req_ready == 0, "R2", "req_ready after reset", req_ready, 0);

    access(0, mk(1, 5, 2), '0, "R2");
    access(0, mk(1, 5, 2), '0, "R3");
    access(0, mk(1, 5, 7), '0, "R3");
    access(1, mk(1, 5, 3), 64'hDEAD_BEEF_0123_4567, "R4");
    access(0, mk(1, 5, 3), '0, "R4");
    access(0, mk(1, 5, 4), '0, "R4");
    access(0, mk(2, 5, 0), '0, "R6");
    access(0, mk(1, 5, 0), '0, "R5");
    access(0, mk(3, 5, 1), '0, "R5");
    // R10: park the dirty line, then miss on it at once
    wb_block = 40;
    access(0, mk(4, 5, 6), '0, "R7");
    access(0, mk(1, 5, 3), '0, "R10");
    // R9: write allocate, merge, later evicted
    access(1, mk(7, 9, 5), 64'h1122_3344_5566_7788, "R9");
    access(0, mk(7, 9, 5), '0, "R9");
    access(0, mk(7, 9, 0), '0, "R9");
    access(0, mk(8, 9, 0), '0, "R6");
    access(0, mk(9, 9, 0), '0, "R9");
    access(0, mk(7, 9, 5), '0, "R9");
    // R1: tag MSB and neighbouring set are distinct
    access(0, mk(0, 6, 1), '0, "R1");
    access(0, mk(25'h1000000, 6, 1), '0, "R1");
    access(0, mk(0, 7, 1), '0, "R1");
    access(0, mk(0, 6, 1), '0, "R1");
    // R10: second write-back waits for the first to drain
    access(1, mk(1, 10, 0), 64'hA, "R10");
    access(1, mk(1, 11, 0), 64'hB, "R10");
    access(0, mk(2, 10, 0), '0, "R10");
    access(0, mk(2, 11, 0), '0, "R10");
    wb_block = 30;
    access(0, mk(3, 10, 0), '0, "R10");
    access(0, mk(3, 11, 0), '0, "R10");
    access(0, mk(1, 10, 0), '0, "R10");
    access(0, mk(1, 11, 0), '0, "R10");
    // Mixed traffic on two sets (R3, R5, R7, R8, R9)
    for (int i = 0; i < 400; i++) begin
      logic [24:0] t = 25'($urandom_range(0, 3));
      logic [8:0]  s = ($urandom_range(0, 1) == 0) ? 9'd12 : 9'd511;
      logic [2:0]  w = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 9) == 0) wb_block = $urandom_range(0, 12);
      access(1'($urandom_range(0, 1)), mk(t, s, w), {$urandom, $urandom}, "R5");
    end
    repeat (60) @(posedge clk);
    #1;
    chk(exp_wb_addr.size() == 0, "R7", "write-backs still owed", exp_wb_addr.size(), 0);
    finish_run();
  end
endmodule